// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block adds mailbox interrupts to a two-port memory of 8K x 16 words. Each port presents an enable, a write strobe, an address and write data. The block keeps one interrupt flag per port. Each direction of traffic has one mailbox word at the top of the address space. When one port writes the other port's mailbox word, the receiving port's interrupt goes low. When the receiving port then reads or writes its own mailbox word, the interrupt is released.

The block also holds the two 16-bit mailbox words, so a message can pass from one port to the other. A read of a mailbox word returns the stored word one clock later, and a select output marks that data as coming from the mailbox. Reads of any other address get no response from this block, because the rest of the array is outside its scope. A global enable turns the interrupt feature off. While it is low, the two top words are still written and read as ordinary storage, but they have no effect on either flag.

Top module: `dpmb_mailbox_top`

## Requirements
- R1: During and after reset, both interrupt outputs are high (inactive), both select outputs are 0, both read data outputs are 0 and both mailbox words read back as 0.
- R2: A right-port write (r_en=1, r_wr=1) to address 0x1FFE while irq_en=1 drives l_irq_n low on the clock after the write.
- R3: A left-port access (l_en=1, read or write) to address 0x1FFE while irq_en=1 returns l_irq_n high on the following clock, unless a set occurs in the same cycle.
- R4: A left-port write to address 0x1FFF while irq_en=1 drives r_irq_n low on the clock after the write.
- R5: A right-port access (r_en=1, read or write) to address 0x1FFF while irq_en=1 returns r_irq_n high on the following clock, unless a set occurs in the same cycle.
- R6: A write strobe without enable, a read (en=1, wr=0) by the opposite port, and a write to any other address leave both interrupt outputs unchanged.
- R7: If a flag is set and cleared in the same cycle, the set wins and the interrupt goes or stays low.
- R8: While irq_en=0, no access changes either interrupt output. Both mailbox words still store writes and return them on reads.
- R9: A read (en=1, wr=0) of 0x1FFE or 0x1FFF returns the 16-bit stored word on rdata, with rsel=1, one clock later. A read of any other address gives rsel=0 and rdata=0.
- R10: When both ports write the same mailbox word in one cycle, the left port's data is stored.
- R11: A read of a mailbox word in the same cycle as a write to it by the other port returns the word's value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_en | input | 1 | 1 = mailbox interrupts on; 0 = top words are plain storage |
| l_en | input | 1 | Left port enable, active high |
| l_wr | input | 1 | Left port write strobe (1 = write, 0 = read) |
| l_addr | input | 13 | Left port word address |
| l_wdata | input | 16 | Left port write data |
| l_rdata | output | 16 | Left mailbox read data, one clock after the read |
| l_rsel | output | 1 | 1 when l_rdata holds a mailbox word |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_en | input | 1 | Right port enable, active high |
| r_wr | input | 1 | Right port write strobe (1 = write, 0 = read) |
| r_addr | input | 13 | Right port word address |
| r_wdata | input | 16 | Right port write data |
| r_rdata | output | 16 | Right mailbox read data, one clock after the read |
| r_rsel | output | 1 | 1 when r_rdata holds a mailbox word |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The embedded properties assume that every port input is a known level at each rising edge and that reset is held low for at least one edge before any access. They also assume that irq_en changes only between accesses and never mid-transaction. The bench keeps to these assumptions: it changes every input only on falling edges, holds reset over several edges, and toggles irq_en only while both ports are idle. Each access lasts exactly one cycle, so every flag and read-data result is sampled on the falling edge that follows the registering edge.

// File: rtl/dpmb_pkg.sv
// Shared definitions for the dual-port mailbox interrupt block.
// Assumes exactly two ports: index 0 is the left port, index 1 the right.
package dpmb_pkg;
    localparam int NPORT = 2;
    localparam int PL    = 0;
    localparam int PR    = 1;

    // Decoded access of one port in one cycle.
    typedef struct packed {
        logic             en;   // port enabled
        logic             wr;   // write strobe
        logic [NPORT-1:0] hit;  // hit[k]: address is mailbox word of port k
    } dpmb_acc_t;

    // A write counts only with enable and strobe both active.
    function automatic logic acc_is_write(dpmb_acc_t a);
        return a.en && a.wr;
    endfunction

    function automatic logic acc_is_read(dpmb_acc_t a);
        return a.en && !a.wr;
    endfunction
endpackage

// File: rtl/dpmb_port_decode.sv
// Decodes one port's access against the two mailbox words.
// Mailbox of port k sits at the top of memory: left = top-1, right = top.
// Assumes: purely combinational, inputs are stable at the clock edge.
module dpmb_port_decode
    import dpmb_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          en,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output dpmb_acc_t     acc
);
    localparam logic [AW-1:0] TOP_ADDR = '1;

    // Compare the address against each port's mailbox word.
    always_comb begin
        acc.en = en;
        acc.wr = wr;
        for (int k = 0; k < NPORT; k++) begin
            acc.hit[k] = (addr == (TOP_ADDR - AW'(NPORT - 1 - k)));
        end
    end
endmodule

// File: rtl/dpmb_irq_flag.sv
// One pending-interrupt flag with an active-low registered output.
// Set has priority over clear; the flag is clear after reset.
// Assumes set/clr are already qualified by the global interrupt enable.
module dpmb_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    logic pend_q;

    // Flag register: set wins over clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend_q <= 1'b0;
        else if (set) pend_q <= 1'b1;
        else if (clr) pend_q <= 1'b0;
    end

    assign irq_n = ~pend_q;

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> irq_n);
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n) set |=> !irq_n);
    // R3
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> irq_n);
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(irq_n));
endmodule

// File: rtl/dpmb_msg_store.sv
// Holds the two mailbox words and serves registered reads of them.
// On a same-word double write the left port wins; reads return the
// value held before any write in the same cycle.
// Assumes decoded accesses from dpmb_port_decode, one per port.
module dpmb_msg_store
    import dpmb_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  dpmb_acc_t     acc   [NPORT],
    input  logic [DW-1:0] wdata [NPORT],
    output logic [DW-1:0] rdata [NPORT],
    output logic          rsel  [NPORT]
);
    logic [DW-1:0] word_q [NPORT];

    for (genvar k = 0; k < NPORT; k++) begin : g_word
        // Mailbox word k: left write first, then right write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[k] <= '0;
            else if (acc_is_write(acc[PL]) && acc[PL].hit[k])
                word_q[k] <= wdata[PL];
            else if (acc_is_write(acc[PR]) && acc[PR].hit[k])
                word_q[k] <= wdata[PR];
        end

        // R10
        left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_is_write(acc[PL]) && acc[PL].hit[k] &&
             acc_is_write(acc[PR]) && acc[PR].hit[k])
            |=> (word_q[k] == $past(wdata[PL])));
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_read
        // Registered read port p: mailbox word or zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[p] <= '0;
                rsel[p]  <= 1'b0;
            end else if (acc_is_read(acc[p]) && |acc[p].hit) begin
                rdata[p] <= acc[p].hit[PR] ? word_q[PR] : word_q[PL];
                rsel[p]  <= 1'b1;
            end else begin
                rdata[p] <= '0;
                rsel[p]  <= 1'b0;
            end
        end

        // R9
        read_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_is_read(acc[p]) && |acc[p].hit) |=> rsel[p]);
        // R9
        no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(acc_is_read(acc[p]) && |acc[p].hit) |=> (!rsel[p] && rdata[p] == '0));
    end
endmodule

// File: rtl/dpmb_mailbox_top.sv
// Dual-port mailbox interrupt controller. Each port's flag is set by the
// opposite port writing that port's mailbox word and cleared by the
// owning port accessing it. irq_en = 0 freezes both flags.
// Assumes one access per port per cycle, inputs stable at the edge.
module dpmb_mailbox_top
    import dpmb_pkg::*;
#(
    parameter int AW = 13,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_en,
    input  logic          l_en,
    input  logic          l_wr,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_rsel,
    output logic          l_irq_n,
    input  logic          r_en,
    input  logic          r_wr,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_rsel,
    output logic          r_irq_n
);
    logic          en_v    [NPORT];
    logic          wr_v    [NPORT];
    logic [AW-1:0] addr_v  [NPORT];
    logic [DW-1:0] wdata_v [NPORT];
    logic [DW-1:0] rdata_v [NPORT];
    logic          rsel_v  [NPORT];
    logic          irq_n_v [NPORT];
    logic          set_v   [NPORT];
    logic          clr_v   [NPORT];
    dpmb_acc_t     acc_v   [NPORT];

    // Gather port pins into per-port arrays.
    always_comb begin
        en_v[PL] = l_en;    wr_v[PL] = l_wr;    addr_v[PL] = l_addr;    wdata_v[PL] = l_wdata;
        en_v[PR] = r_en;    wr_v[PR] = r_wr;    addr_v[PR] = r_addr;    wdata_v[PR] = r_wdata;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpmb_port_decode #(.AW(AW)) i_decode (
            .en   (en_v[p]),
            .wr   (wr_v[p]),
            .addr (addr_v[p]),
            .acc  (acc_v[p])
        );

        // Set from the opposite port's write, clear from own access.
        always_comb begin
            set_v[p] = irq_en && acc_is_write(acc_v[NPORT-1-p]) && acc_v[NPORT-1-p].hit[p];
            clr_v[p] = irq_en && acc_v[p].en && acc_v[p].hit[p];
        end

        dpmb_irq_flag i_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_v[p]),
            .clr   (clr_v[p]),
            .irq_n (irq_n_v[p])
        );
    end

    dpmb_msg_store #(.DW(DW)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc_v),
        .wdata (wdata_v),
        .rdata (rdata_v),
        .rsel  (rsel_v)
    );

    assign l_rdata = rdata_v[PL];
    assign r_rdata = rdata_v[PR];
    assign l_rsel  = rsel_v[PL];
    assign r_rsel  = rsel_v[PR];
    assign l_irq_n = irq_n_v[PL];
    assign r_irq_n = irq_n_v[PR];

    localparam logic [AW-1:0] MB_L = {{(AW-1){1'b1}}, 1'b0};
    localparam logic [AW-1:0] MB_R = '1;

    // R8
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> ($stable(l_irq_n) && $stable(r_irq_n)));
    // R2
    left_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && r_en && r_wr && r_addr == MB_L) |=> !l_irq_n);
    // R4
    right_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && l_en && l_wr && l_addr == MB_R) |=> !r_irq_n);
    // R5
    right_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && r_en && r_addr == MB_R && !(l_en && l_wr && l_addr == MB_R)) |=> r_irq_n);
endmodule

// File: tb/test_dpmb_mailbox_top.sv
`timescale 1ns/1ps
module test_dpmb_mailbox_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_en = 1'b0;
    logic        l_en = 0, l_wr = 0, r_en = 0, r_wr = 0;
    logic [12:0] l_addr = '0, r_addr = '0;
    logic [15:0] l_wdata = '0, r_wdata = '0;
    logic [15:0] l_rdata, r_rdata;
    logic        l_rsel, r_rsel, l_irq_n, r_irq_n;
    int          n_chk = 0, n_bad = 0;

    localparam logic [12:0] MBL = 13'h1FFE;
    localparam logic [12:0] MBR = 13'h1FFF;

    always #5 clk = ~clk;

    dpmb_mailbox_top i_dpmb_mailbox_top (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
        .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_rsel(l_rsel), .l_irq_n(l_irq_n),
        .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_rsel(r_rsel), .r_irq_n(r_irq_n)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One-cycle access on both ports; returns on the falling edge after it.
    task automatic access(input logic le, lw, input logic [12:0] la, input logic [15:0] ld,
                          input logic re, rw, input logic [12:0] ra, input logic [15:0] rd);
        @(negedge clk);
        l_en = le; l_wr = lw; l_addr = la; l_wdata = ld;
        r_en = re; r_wr = rw; r_addr = ra; r_wdata = rd;
        @(negedge clk);
        l_en = 0; l_wr = 0; r_en = 0; r_wr = 0;
    endtask

    task automatic t_reset;
        chk("R1 l_irq_n", l_irq_n, 1);
        chk("R1 r_irq_n", r_irq_n, 1);
        chk("R1 l_rsel", l_rsel, 0);
        chk("R1 r_rdata", r_rdata, 0);
        access(1, 0, MBR, 0, 1, 0, MBL, 0);
        chk("R1 word right reset", l_rdata, 0);
        chk("R1 word left reset", r_rdata, 0);
    endtask

    task automatic t_left_mail;
        access(0, 0, 0, 0, 1, 1, MBL, 16'hA5A5);
        chk("R2 l_irq_n set", l_irq_n, 0);
        chk("R2 r_irq_n untouched", r_irq_n, 1);
        access(1, 0, MBL, 0, 0, 0, 0, 0);
        chk("R9 l_rdata", l_rdata, 16'hA5A5);
        chk("R9 l_rsel", l_rsel, 1);
        chk("R3 l_irq_n cleared", l_irq_n, 1);
    endtask

    task automatic t_right_mail;
        access(1, 1, MBR, 16'h1234, 0, 0, 0, 0);
        chk("R4 r_irq_n set", r_irq_n, 0);
        access(0, 0, 0, 0, 1, 1, MBR, 16'h4321);
        chk("R5 r_irq_n cleared by write", r_irq_n, 1);
        access(0, 0, 0, 0, 1, 0, MBR, 0);
        chk("R9 r_rdata", r_rdata, 16'h4321);
        access(1, 1, MBR, 16'h5555, 0, 0, 0, 0);
        access(0, 0, 0, 0, 1, 0, MBR, 0);
        chk("R5 r_irq_n cleared by read", r_irq_n, 1);
    endtask

    task automatic t_qualify;
        access(0, 0, 0, 0, 0, 1, MBL, 16'hDEAD);
        chk("R6 strobe without enable", l_irq_n, 1);
        access(0, 0, 0, 0, 1, 0, MBL, 0);
        chk("R6 opposite read", l_irq_n, 1);
        access(0, 0, 0, 0, 1, 1, 13'h1FFD, 16'hBEEF);
        chk("R6 other address", l_irq_n, 1);
        access(1, 0, 13'h1FFD, 0, 0, 0, 0, 0);
        chk("R9 non-mailbox rsel", l_rsel, 0);
        chk("R9 non-mailbox rdata", l_rdata, 0);
        access(1, 0, MBL, 0, 0, 0, 0, 0);
        chk("R6 word unchanged by disabled write", l_rdata, 16'hA5A5);
    endtask

    task automatic t_collide;
        access(1, 0, MBL, 0, 1, 1, MBL, 16'h0F0F);
        chk("R7 set wins over clear", l_irq_n, 0);
        chk("R11 read sees old word", l_rdata, 16'hA5A5);
        access(1, 0, MBL, 0, 0, 0, 0, 0);
        chk("R11 new word after", l_rdata, 16'h0F0F);
        chk("R3 cleared after collide", l_irq_n, 1);
    endtask

    task automatic t_disabled;
        access(1, 1, MBR, 16'h7777, 0, 0, 0, 0);
        chk("R4 set before disable", r_irq_n, 0);
        irq_en = 0;
        access(0, 0, 0, 0, 1, 0, MBR, 0);
        chk("R8 read does not clear", r_irq_n, 0);
        chk("R8 storage read", r_rdata, 16'h7777);
        access(0, 0, 0, 0, 1, 1, MBL, 16'h3C3C);
        chk("R8 write does not set", l_irq_n, 1);
        access(1, 0, MBL, 0, 0, 0, 0, 0);
        chk("R8 storage write kept", l_rdata, 16'h3C3C);
        irq_en = 1;
        access(0, 0, 0, 0, 1, 0, MBR, 0);
        chk("R5 clear after re-enable", r_irq_n, 1);
    endtask

    task automatic t_both_write;
        access(1, 1, MBR, 16'h1111, 1, 1, MBR, 16'h2222);
        chk("R7 set wins on double write", r_irq_n, 0);
        access(0, 0, 0, 0, 1, 0, MBR, 0);
        chk("R10 left data kept", r_rdata, 16'h1111);
        chk("R5 cleared", r_irq_n, 1);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_pre: begin
            chk("R1 l_irq_n in reset", l_irq_n, 1);
        end
        rst_n = 1;
        @(negedge clk);
        t_reset();
        irq_en = 1;
        t_left_mail();
        t_right_mail();
        t_qualify();
        t_collide();
        t_disabled();
        t_both_write();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule